// File: doc/BRIEF.md
# Window Integral Image Calculator

This block turns one square window of 8-bit grayscale pixels into two summed-area tables. One table accumulates the raw pixel values. The other accumulates the squares of the pixel values over the same window. A downstream cascade classifier reads the first table to get rectangle sums in a few lookups. It reads the second table to get the window variance, which it uses to normalise its feature thresholds.

A whole window arrives at once on a valid/ready handshake. Processing runs in two pipeline stages. The row stage squares every pixel and forms running sums along each row, for both the plain and the squared values. The column stage adds those row sums down each column to give the finished tables. Both tables leave as flat arrays together with an output valid, and a consumer takes them with its ready.

A small control state machine tracks which stages hold a window. Its states are:

- `PS_IDLE`: both stages empty.
- `PS_ROW`: only the row stage full.
- `PS_COL`: only the column stage full.
- `PS_BOTH`: both stages full.

Its transitions are:

- `accept`: a window enters the row stage.
- `advance`: the row stage passes its window to the column stage.
- `drain`: the consumer takes the tables.

Because of these states, the block takes one window per cycle as long as the consumer keeps up. When the consumer stalls, the block holds at most two windows.

Top module: `integral_window`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high.
- R2: A window is accepted only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when both stages hold a window and `out_ready` is low.
- R3: A window accepted on edge n into an empty pipeline raises `out_valid` after edge n+1, with its tables on the outputs.
- R4: Pixel (r,c) sits at `in_pixels[(r*25+c)*8 +: 8]`. The plain table is 18 bits per entry, and entry (r,c) sits at `out_sum[(r*25+c)*18 +: 18]`. That entry is the sum of all pixels with row ≤ r and column ≤ c, with no zero padding row or column.
- R5: The squared table is 26 bits per entry, and entry (r,c) sits at `out_sqsum[(r*25+c)*26 +: 26]`. That entry is the sum of the squared pixels over the same region as in R4.
- R6: A window of all 255 gives, at entry (24,24), 159375 in the plain table and 40640625 in the squared table, with no overflow.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and both tables stay unchanged.
- R8: With `out_ready` held high, windows are accepted on consecutive cycles, one per cycle.
- R9: Every accepted window leaves exactly once, in the order it was accepted, under any pattern of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input window present |
| in_ready | output | 1 | Block can take a window this cycle |
| in_pixels | input | 5000 | 625 pixels, 8 bits each, row-major |
| out_valid | output | 1 | Tables on the outputs are valid |
| out_ready | input | 1 | Consumer takes the tables this cycle |
| out_sum | output | 11250 | Plain table, 625 entries of 18 bits, row-major |
| out_sqsum | output | 16250 | Squared table, 625 entries of 26 bits, row-major |

## Verification
The first result is `in_ready`. It depends only on the current state and `out_ready`, so it is due in the same cycle as the consumer's ready. The tables and `out_valid` are due two edges after acceptance when the pipeline is empty, and later only if the consumer has stalled. The bench keeps a two-slot behavioural model that it steps on each rising edge from the same handshake rules. It compares both handshake outputs, and the full tables whenever the model's output slot is full, one time unit after every falling edge. That way each expected value is taken in the exact cycle the model says it is due.

// File: rtl/intimg_pkg.sv
package intimg_pkg;

    // Occupancy of the two pipeline stages.
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_ROW  = 2'd1,
        PS_COL  = 2'd2,
        PS_BOTH = 2'd3
    } pipe_state_t;

    // Number of bits needed to hold the value v.
    function automatic int bits_for(longint unsigned v);
        int n;
        n = 0;
        while (v > 0) begin
            n++;
            v = v >> 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/intimg_ctrl.sv
module intimg_ctrl
    import intimg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic load_row,
    output logic load_col,
    output logic out_valid
);

    pipe_state_t state_q;
    pipe_state_t state_d;
    logic        accept;
    logic        drain;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            PS_IDLE: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                load_col  = 1'b0;
            end
            PS_ROW: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                load_col  = 1'b1;
            end
            PS_COL: begin
                in_ready  = 1'b1;
                out_valid = 1'b1;
                load_col  = 1'b0;
            end
            PS_BOTH: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
                load_col  = out_ready;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
                load_col  = 1'b0;
            end
        endcase
        load_row = in_valid && in_ready;
    end

    assign accept = in_valid && in_ready;
    assign drain  = out_valid && out_ready;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: state_d = accept ? PS_ROW : PS_IDLE;
            PS_ROW:  state_d = accept ? PS_BOTH : PS_COL;
            PS_COL: begin
                if (drain) state_d = accept ? PS_ROW : PS_IDLE;
                else       state_d = accept ? PS_BOTH : PS_COL;
            end
            PS_BOTH: begin
                if (drain) state_d = accept ? PS_BOTH : PS_COL;
                else       state_d = PS_BOTH;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_room_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && state_q == PS_IDLE) |=> ##1 out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/intimg_rowscan.sv
module intimg_rowscan #(
    parameter int WIN   = 25,
    parameter int PIX_W = 8,
    parameter int ROW_W = 13,
    parameter int RSQ_W = 21
) (
    input  logic                     clk,
    input  logic                     load,
    input  logic [WIN*WIN*PIX_W-1:0] pix,
    output logic [WIN*WIN*ROW_W-1:0] row_sum,
    output logic [WIN*WIN*RSQ_W-1:0] row_sq
);

    localparam int CELLS = WIN * WIN;
    localparam int SQP_W = 2 * PIX_W;

    logic [SQP_W-1:0]         sq [CELLS];
    logic [CELLS*ROW_W-1:0]   row_c;
    logic [CELLS*RSQ_W-1:0]   rowq_c;

    // One squarer per pixel, finished before the row sums use it.
    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_sq
            logic [PIX_W-1:0] p;
            assign p     = pix[i*PIX_W +: PIX_W];
            assign sq[i] = SQP_W'(p) * SQP_W'(p);
        end
    endgenerate

    // Running sums along each row.
    always_comb begin
        logic [ROW_W-1:0] run;
        logic [RSQ_W-1:0] runq;
        row_c  = '0;
        rowq_c = '0;
        for (int r = 0; r < WIN; r++) begin
            run  = '0;
            runq = '0;
            for (int c = 0; c < WIN; c++) begin
                run  = run + ROW_W'(pix[(r*WIN+c)*PIX_W +: PIX_W]);
                runq = runq + RSQ_W'(sq[r*WIN+c]);
                row_c[(r*WIN+c)*ROW_W +: ROW_W]  = run;
                rowq_c[(r*WIN+c)*RSQ_W +: RSQ_W] = runq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            row_sum <= row_c;
            row_sq  <= rowq_c;
        end
    end

endmodule

// File: rtl/intimg_colsum.sv
module intimg_colsum #(
    parameter int WIN   = 25,
    parameter int ROW_W = 13,
    parameter int RSQ_W = 21,
    parameter int SUM_W = 18,
    parameter int SQ_W  = 26
) (
    input  logic                     clk,
    input  logic                     load,
    input  logic [WIN*WIN*ROW_W-1:0] row_sum,
    input  logic [WIN*WIN*RSQ_W-1:0] row_sq,
    output logic [WIN*WIN*SUM_W-1:0] tab_sum,
    output logic [WIN*WIN*SQ_W-1:0]  tab_sq
);

    localparam int CELLS = WIN * WIN;

    logic [CELLS*SUM_W-1:0] sum_c;
    logic [CELLS*SQ_W-1:0]  sq_c;

    // Accumulate the row sums down each column.
    always_comb begin
        logic [SUM_W-1:0] run;
        logic [SQ_W-1:0]  runq;
        sum_c = '0;
        sq_c  = '0;
        for (int c = 0; c < WIN; c++) begin
            run  = '0;
            runq = '0;
            for (int r = 0; r < WIN; r++) begin
                run  = run + SUM_W'(row_sum[(r*WIN+c)*ROW_W +: ROW_W]);
                runq = runq + SQ_W'(row_sq[(r*WIN+c)*RSQ_W +: RSQ_W]);
                sum_c[(r*WIN+c)*SUM_W +: SUM_W] = run;
                sq_c[(r*WIN+c)*SQ_W +: SQ_W]    = runq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            tab_sum <= sum_c;
            tab_sq  <= sq_c;
        end
    end

endmodule

// File: rtl/integral_window.sv
module integral_window
    import intimg_pkg::*;
#(
    parameter  int WIN   = 25,
    parameter  int PIX_W = 8,
    localparam int PMAX  = (1 << PIX_W) - 1,
    localparam int ROW_W = bits_for(longint'(WIN) * PMAX),
    localparam int RSQ_W = bits_for(longint'(WIN) * PMAX * PMAX),
    localparam int SUM_W = bits_for(longint'(WIN) * WIN * PMAX),
    localparam int SQ_W  = bits_for(longint'(WIN) * WIN * PMAX * PMAX)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [WIN*WIN*PIX_W-1:0] in_pixels,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [WIN*WIN*SUM_W-1:0] out_sum,
    output logic [WIN*WIN*SQ_W-1:0]  out_sqsum
);

    logic                     load_row;
    logic                     load_col;
    logic [WIN*WIN*ROW_W-1:0] row_sum;
    logic [WIN*WIN*RSQ_W-1:0] row_sq;

    intimg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load_row  (load_row),
        .load_col  (load_col),
        .out_valid (out_valid)
    );

    intimg_rowscan #(
        .WIN   (WIN),
        .PIX_W (PIX_W),
        .ROW_W (ROW_W),
        .RSQ_W (RSQ_W)
    ) u_rows (
        .clk     (clk),
        .load    (load_row),
        .pix     (in_pixels),
        .row_sum (row_sum),
        .row_sq  (row_sq)
    );

    intimg_colsum #(
        .WIN   (WIN),
        .ROW_W (ROW_W),
        .RSQ_W (RSQ_W),
        .SUM_W (SUM_W),
        .SQ_W  (SQ_W)
    ) u_cols (
        .clk     (clk),
        .load    (load_col),
        .row_sum (row_sum),
        .row_sq  (row_sq),
        .tab_sum (out_sum),
        .tab_sq  (out_sqsum)
    );

    assert_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_sum) && $stable(out_sqsum)));

endmodule

// File: tb/integral_window_bench.sv
`timescale 1ns/100ps
module integral_window_bench;

    localparam int W  = 25;
    localparam int N  = W * W;
    localparam int PW = 8;
    localparam int SW = 18;
    localparam int QW = 26;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            out_ready = 1'b1;
    logic [N*PW-1:0] in_pixels = '0;
    logic            in_ready;
    logic            out_valid;
    logic [N*SW-1:0] out_sum;
    logic [N*QW-1:0] out_sqsum;

    always #2 clk = ~clk;

    integral_window u_integral_window (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pixels (in_pixels),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sum   (out_sum),
        .out_sqsum (out_sqsum)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int accepted = 0;
    int delivered = 0;
    int ready_mode = 1;
    bit done = 1'b0;
    bit held_prev = 1'b0;

    // Two-slot behavioural model.
    bit m1v = 1'b0;
    bit m2v = 1'b0;
    int m1_pl[N];
    int m1_sq[N];
    int m2_pl[N];
    int m2_sq[N];
    int nb_pl[N];
    int nb_sq[N];

    function automatic bit m_ready();
        return !m1v || !m2v || out_ready;
    endfunction

    task automatic fail(input string req, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic build();
        for (int r = 0; r < W; r++) begin
            for (int c = 0; c < W; c++) begin
                int k;
                int p;
                k = r * W + c;
                p = int'(in_pixels[k*PW +: PW]);
                nb_pl[k] = p;
                nb_sq[k] = p * p;
                if (r > 0) begin
                    nb_pl[k] += nb_pl[k-W];
                    nb_sq[k] += nb_sq[k-W];
                end
                if (c > 0) begin
                    nb_pl[k] += nb_pl[k-1];
                    nb_sq[k] += nb_sq[k-1];
                end
                if (r > 0 && c > 0) begin
                    nb_pl[k] -= nb_pl[k-W-1];
                    nb_sq[k] -= nb_sq[k-W-1];
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m1v = 1'b0;
            m2v = 1'b0;
        end else begin
            bit acc;
            bit adv;
            bit drn;
            acc = in_valid && m_ready();
            adv = m1v && (!m2v || out_ready);
            drn = m2v && out_ready;
            if (adv) begin
                m2_pl = m1_pl;
                m2_sq = m1_sq;
                m2v = 1'b1;
            end else if (drn) begin
                m2v = 1'b0;
            end
            if (acc) begin
                build();
                m1_pl = nb_pl;
                m1_sq = nb_sq;
                m1v = 1'b1;
                accepted++;
            end else if (adv) begin
                m1v = 1'b0;
            end
        end
    end

    // Consumer ready pattern.
    always @(negedge clk) begin
        case (ready_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = ($urandom % 3) != 0;
        endcase
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            checks++;
            if (out_valid !== m2v) fail("R3", "out_valid", out_valid, m2v);
            checks++;
            if (in_ready !== m_ready()) fail("R2", "in_ready", in_ready, m_ready());
            if (m2v && out_valid) begin
                int bad_pl;
                int bad_sq;
                bad_pl = -1;
                bad_sq = -1;
                for (int k = 0; k < N; k++) begin
                    if (bad_pl < 0 && int'(out_sum[k*SW +: SW]) != m2_pl[k]) bad_pl = k;
                    if (bad_sq < 0 && int'(out_sqsum[k*QW +: QW]) != m2_sq[k]) bad_sq = k;
                end
                checks++;
                if (bad_pl >= 0)
                    fail(held_prev ? "R7" : "R4", $sformatf("plain entry %0d", bad_pl),
                         out_sum[bad_pl*SW +: SW], m2_pl[bad_pl]);
                checks++;
                if (bad_sq >= 0)
                    fail(held_prev ? "R7" : "R5", $sformatf("squared entry %0d", bad_sq),
                         out_sqsum[bad_sq*QW +: QW], m2_sq[bad_sq]);
                if (out_ready) delivered++;
            end
            held_prev = m2v && !out_ready;
        end
    end

    function automatic logic [N*PW-1:0] make_win(input int kind);
        logic [N*PW-1:0] w;
        for (int r = 0; r < W; r++) begin
            for (int c = 0; c < W; c++) begin
                logic [PW-1:0] p;
                case (kind)
                    0:       p = 8'd0;
                    1:       p = 8'd255;
                    2:       p = 8'((r * 7 + c * 13) % 256);
                    3:       p = ((r + c) % 2 == 0) ? 8'd255 : 8'd0;
                    default: p = 8'($urandom);
                endcase
                w[(r*W+c)*PW +: PW] = p;
            end
        end
        return w;
    endfunction

    task automatic send_win(input logic [N*PW-1:0] w);
        @(negedge clk);
        in_pixels = w;
        in_valid = 1'b1;
        #1;
        while (!m_ready()) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_empty();
        ready_mode = 1;
        while (m1v || m2v) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int t0;
        int t1;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0) fail("R1", "out_valid in reset", out_valid, 0);
        checks++;
        if (in_ready !== 1'b1) fail("R1", "in_ready in reset", in_ready, 1);
        rst = 1'b0;

        // R4 R5: zero, ramp and checker windows, one at a time.
        send_win(make_win(0));
        go_idle();
        wait_empty();
        send_win(make_win(2));
        go_idle();
        wait_empty();
        send_win(make_win(3));
        go_idle();
        wait_empty();

        // R6: all-255 window, corner entry.
        send_win(make_win(1));
        go_idle();
        seen = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (out_valid) begin
                seen = 1'b1;
                checks++;
                if (out_sum[(N-1)*SW +: SW] != SW'(159375))
                    fail("R6", "plain corner", out_sum[(N-1)*SW +: SW], 159375);
                checks++;
                if (out_sqsum[(N-1)*QW +: QW] != QW'(40640625))
                    fail("R6", "squared corner", out_sqsum[(N-1)*QW +: QW], 40640625);
            end
        end
        checks++;
        if (!seen) fail("R3", "all-255 window never appeared", 0, 1);
        wait_empty();

        // R8: back-to-back windows with the consumer always ready.
        @(posedge clk);
        #0.5;
        t0 = cyc;
        for (int i = 0; i < 6; i++) send_win(make_win(4));
        #0.5;
        t1 = cyc;
        go_idle();
        checks++;
        if (t1 - t0 != 6) fail("R8", "cycles for six windows", t1 - t0, 6);
        wait_empty();

        // R2 R7: stall the consumer with both stages full.
        ready_mode = 0;
        @(negedge clk);
        send_win(make_win(2));
        send_win(make_win(4));
        fork
            begin
                repeat (2) @(negedge clk);
                #1;
                checks++;
                if (in_ready !== 1'b0) fail("R2", "in_ready with both stages full", in_ready, 0);
                repeat (4) @(negedge clk);
                ready_mode = 1;
            end
            send_win(make_win(3));
        join
        go_idle();
        wait_empty();

        // R9: random consumer ready over a stream of windows.
        ready_mode = 2;
        for (int i = 0; i < 12; i++) send_win(make_win(i % 3 == 0 ? 1 : 4));
        go_idle();
        wait_empty();
        checks++;
        if (delivered != accepted) fail("R9", "windows delivered vs accepted", delivered, accepted);

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fail("R9", "watchdog expired, stream hung", 0, 1);
            summary();
        end
    end

endmodule